// File: doc/BRIEF.md
# Sub-Clock Resolution Buck Gate-Timing Generator

This block times the two gate enables of one synchronous buck switching channel. Each switching period is counted in whole cycles of the master clock, and every edge inside the period is placed on a grid one sixteenth of a clock wide. Every edge the block emits is reported twice: as a change of the coarse level output in the clock cycle that contains it, and as a one-cycle strobe carrying a 4-bit fine-phase code. An external delay stage uses that code to shift the edge inside the cycle. With a 103 MHz master clock one fine step is close to 607 ps.

A control engine supplies a duty command in fine steps. Per-channel settings supply the period (in whole clocks), the two dead times, the minimum and maximum high-side on-time and the minimum low-side time (all in fine steps). The block samples the command once per period, clamps it against the limits, and builds a fixed sequence: low side off at the period start, first dead time, high-side pulse, second dead time, low side on until the period ends. A channel enable stops switching at once and restarts the period from its first cycle.

Top module: `hrpwm_channel`

## Requirements
- R1: The high-side output `gh` and the low-side output `gl` are never both high in the same cycle.
- R2: While enabled, `period_start` pulses once every max(`period_clk`,2) clocks. The period value is sampled in the first cycle of each period, and a change later in the period affects only later periods.
- R3: `duty_cmd` and all timing settings are sampled only in the first cycle of a period, and changes inside a period do not alter that period's edges.
- R4: A time value T in fine steps belongs to period cycle T/16 with fine code T mod 16. A strobe (`gh_edge` or `gl_edge`) is high exactly in the output cycle where the matching level changes. Its fine code is that edge's T mod 16, except that a low-side fall at the period start has code 0. Both fine codes are 0 whenever their strobe is low.
- R5: With A and B the effective dead times and W the clamped on-time, the high side is high for cycles k with A/16 <= k < (A+W)/16. The low side is high for cycles k >= (A+W+B)/16 until the period ends. Outputs for period cycle k appear in the clock after that cycle is counted.
- R6: The on-time is raised to at least the larger of the minimum on-time setting and 16 fine steps (one clock).
- R7: The on-time is then lowered to at most the smaller of the maximum on-time setting and 16*P - A - B - min_off (floored at 0, P the effective period). This upper bound wins over R6.
- R8: A dead-time setting of 0 acts as 1 fine step.
- R9: Under reset, and in the clock after `chan_en` is seen low, all outputs are 0. The period counter restarts at cycle 0 on the first clock with `chan_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low stops switching |
| duty_cmd | input | 14 | Requested high-side on-time, fine steps |
| period_clk | input | 10 | Switching period in master clocks |
| dead_lh | input | 14 | Delay from low-side off to high-side on, fine steps |
| dead_hl | input | 14 | Delay from high-side off to low-side on, fine steps |
| min_on | input | 14 | Minimum high-side on-time, fine steps |
| max_on | input | 14 | Maximum high-side on-time, fine steps |
| min_off | input | 14 | Minimum low-side time at period end, fine steps |
| gh | output | 1 | High-side gate enable, coarse level |
| gl | output | 1 | Low-side gate enable, coarse level |
| gh_edge | output | 1 | Strobe: `gh` changed this cycle |
| gh_fine | output | 4 | Fine-phase code of the `gh` edge |
| gl_edge | output | 1 | Strobe: `gl` changed this cycle |
| gl_fine | output | 4 | Fine-phase code of the `gl` edge |
| period_start | output | 1 | First output cycle of a period |

## Verification
A corrupted period counter appears within one period as `period_start` spacing that does not match the sampled period, and as edges at the wrong cycle. A wrong clamp, dead-time floor or latched command shows in the first period that uses it, as an edge one or more cycles off or a wrong fine code. A broken strobe or level register shows in the very next output cycle as a strobe without a level change, a nonzero code with no strobe, or both gates high. The bench compares every output in every cycle against its own schedule model, so each of these faults surfaces in the cycle where it first occurs.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;
  localparam int COARSE_W   = 10;
  localparam int FINE_W     = 4;
  localparam int TICK_W     = COARSE_W + FINE_W;
  localparam int SUM_W      = TICK_W + 2;
  localparam int MIN_PERIOD = 2;
  localparam int CLK_TICKS  = 1 << FINE_W;

  typedef logic [COARSE_W-1:0] coarse_t;
  typedef logic [TICK_W-1:0]   tick_t;
  typedef logic [SUM_W-1:0]    sum_t;
  typedef logic [FINE_W-1:0]   fine_t;

  // One switching period worth of edge times, all in fine steps from period start
  typedef struct packed {
    coarse_t per;
    sum_t    hs_on;
    sum_t    hs_off;
    sum_t    ls_on;
    sum_t    ls_end;
  } sched_t;

  function automatic coarse_t period_floor(coarse_t p);
    return (p < coarse_t'(MIN_PERIOD)) ? coarse_t'(MIN_PERIOD) : p;
  endfunction

  function automatic sum_t dead_floor(tick_t d);
    return (d == '0) ? sum_t'(1) : sum_t'(d);
  endfunction

  function automatic sum_t on_floor(tick_t mn);
    return (sum_t'(mn) > sum_t'(CLK_TICKS)) ? sum_t'(mn) : sum_t'(CLK_TICKS);
  endfunction

  function automatic sum_t on_ceiling(sum_t span, sum_t da, sum_t db,
                                      tick_t moff, tick_t mx);
    sum_t need;
    sum_t room;
    need = da + db + sum_t'(moff);
    room = (span > need) ? (span - need) : '0;
    return (sum_t'(mx) < room) ? sum_t'(mx) : room;
  endfunction

  function automatic sum_t clamp_on(sum_t req, sum_t lo, sum_t hi);
    sum_t v;
    v = (req < lo) ? lo : req;
    return (v > hi) ? hi : v;
  endfunction

  function automatic sum_t cycle_of(sum_t t);
    return t >> FINE_W;
  endfunction

  function automatic fine_t phase_of(sum_t t);
    return t[FINE_W-1:0];
  endfunction
endpackage

// File: rtl/hrpwm_sched.sv
module hrpwm_sched
  import hrpwm_pkg::*;
(
  input  tick_t   duty_cmd,
  input  coarse_t period_clk,
  input  tick_t   dead_lh,
  input  tick_t   dead_hl,
  input  tick_t   min_on,
  input  tick_t   max_on,
  input  tick_t   min_off,
  output sched_t  sched,
  output sum_t    on_lo,
  output sum_t    on_hi
);
  coarse_t per_eff;
  sum_t    span;
  sum_t    da;
  sum_t    db;
  sum_t    width;

  always_comb begin
    per_eff = period_floor(period_clk);
    span    = sum_t'(per_eff) << FINE_W;
    da      = dead_floor(dead_lh);
    db      = dead_floor(dead_hl);
    on_lo   = on_floor(min_on);
    on_hi   = on_ceiling(span, da, db, min_off, max_on);
    width   = clamp_on(sum_t'(duty_cmd), on_lo, on_hi);
    sched.per    = per_eff;
    sched.hs_on  = da;
    sched.hs_off = da + width;
    sched.ls_on  = da + width + db;
    sched.ls_end = span;
  end

  // R7: the upper bound has the last word over the lower one
  always_comb begin
    assert_clamp_ceiling_R7: assert (width <= on_hi);
  end
endmodule

// File: rtl/hrpwm_timer.sv
module hrpwm_timer
  import hrpwm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  sched_t  sched_in,
  output coarse_t cnt,
  output logic    at_start,
  output sched_t  sched_cur
);
  coarse_t cnt_q;
  sched_t  sched_q;
  logic    wrap;

  assign at_start  = en && (cnt_q == '0);
  assign sched_cur = (cnt_q == '0) ? sched_in : sched_q;
  assign wrap      = (cnt_q == sched_cur.per - coarse_t'(1));
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sched_q <= '0;
    end else if (!en) begin
      cnt_q   <= '0;
    end else begin
      if (cnt_q == '0) sched_q <= sched_in;
      cnt_q <= wrap ? '0 : cnt_q + coarse_t'(1);
    end
  end

  // R2: counter stays inside the period latched for it
  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < sched_q.per));

  // R3: the latched schedule only moves in a period's first cycle
  assert_sched_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) != '0) |-> $stable(sched_q));
endmodule

// File: rtl/hrpwm_edge.sv
module hrpwm_edge
  import hrpwm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  coarse_t cnt,
  input  sum_t    on_t,
  input  sum_t    off_t,
  output logic    lvl_q,
  output logic    edge_q,
  output fine_t   fine_q
);
  sum_t  k_w;
  sum_t  on_c;
  sum_t  off_c;
  logic  lvl;
  logic  change;
  fine_t code;

  always_comb begin
    k_w    = sum_t'(cnt);
    on_c   = cycle_of(on_t);
    off_c  = cycle_of(off_t);
    lvl    = (k_w >= on_c) && (k_w < off_c);
    change = (lvl != lvl_q);
    if (!change)      code = '0;
    else if (lvl)     code = phase_of(on_t);
    else if (k_w == off_c) code = phase_of(off_t);
    else              code = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      edge_q <= 1'b0;
      fine_q <= '0;
    end else if (!en) begin
      lvl_q  <= 1'b0;
      edge_q <= 1'b0;
      fine_q <= '0;
    end else begin
      lvl_q  <= lvl;
      edge_q <= change;
      fine_q <= code;
    end
  end

  // R4: no fine code without a strobe
  assert_code_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_q |-> (fine_q == '0));

  // R4: strobe marks exactly a level change
  assert_strobe_is_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && $past(en)) |-> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/hrpwm_channel.sv
module hrpwm_channel
  import hrpwm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chan_en,
  input  logic [TICK_W-1:0]   duty_cmd,
  input  logic [COARSE_W-1:0] period_clk,
  input  logic [TICK_W-1:0]   dead_lh,
  input  logic [TICK_W-1:0]   dead_hl,
  input  logic [TICK_W-1:0]   min_on,
  input  logic [TICK_W-1:0]   max_on,
  input  logic [TICK_W-1:0]   min_off,
  output logic                gh,
  output logic                gl,
  output logic                gh_edge,
  output logic [FINE_W-1:0]   gh_fine,
  output logic                gl_edge,
  output logic [FINE_W-1:0]   gl_fine,
  output logic                period_start
);
  localparam int N_GATES = 2;
  localparam int HS = 0;
  localparam int LS = 1;

  sched_t  sched_new;
  sched_t  sched_cur;
  sum_t    on_lo;
  sum_t    on_hi;
  coarse_t cnt;
  logic    at_start;
  logic    start_q;

  sum_t    rise_t [N_GATES];
  sum_t    fall_t [N_GATES];
  logic    lvl    [N_GATES];
  logic    strobe [N_GATES];
  fine_t   code   [N_GATES];

  hrpwm_sched u_sched (
    .duty_cmd   (duty_cmd),
    .period_clk (period_clk),
    .dead_lh    (dead_lh),
    .dead_hl    (dead_hl),
    .min_on     (min_on),
    .max_on     (max_on),
    .min_off    (min_off),
    .sched      (sched_new),
    .on_lo      (on_lo),
    .on_hi      (on_hi)
  );

  hrpwm_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (chan_en),
    .sched_in  (sched_new),
    .cnt       (cnt),
    .at_start  (at_start),
    .sched_cur (sched_cur)
  );

  assign rise_t[HS] = sched_cur.hs_on;
  assign fall_t[HS] = sched_cur.hs_off;
  assign rise_t[LS] = sched_cur.ls_on;
  assign fall_t[LS] = sched_cur.ls_end;

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    hrpwm_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (chan_en),
      .cnt    (cnt),
      .on_t   (rise_t[g]),
      .off_t  (fall_t[g]),
      .lvl_q  (lvl[g]),
      .edge_q (strobe[g]),
      .fine_q (code[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= at_start;
  end

  assign gh           = lvl[HS];
  assign gl           = lvl[LS];
  assign gh_edge      = strobe[HS];
  assign gh_fine      = code[HS];
  assign gl_edge      = strobe[LS];
  assign gl_fine      = code[LS];
  assign period_start = start_q;

  // R1: gates never overlap
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh && gl));

  // R9: disable clears every output in the next cycle
  assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!gh && !gl && !gh_edge && !gl_edge && !period_start));

  // R5: the high side can only rise while the low side is already off
  assert_hs_rise_ls_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gh_edge && gh) |-> !gl);
endmodule

// File: tb/hrpwm_channel_test.sv
module hrpwm_channel_test;
  import hrpwm_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0;
  logic [TICK_W-1:0]   duty_cmd = '0;
  logic [COARSE_W-1:0] period_clk = '0;
  logic [TICK_W-1:0]   dead_lh = '0, dead_hl = '0, min_on = '0, max_on = '0, min_off = '0;
  logic gh, gl, gh_edge, gl_edge, period_start;
  logic [FINE_W-1:0] gh_fine, gl_fine;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int m_cnt = 0, m_per = 2, m_rise = 0, m_fall = 0, m_lson = 0;
  bit m_gh = 0, m_gl = 0;
  logic [12:0] expv;

  always #(CLK_PERIOD/2) clk = ~clk;

  hrpwm_channel uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .duty_cmd(duty_cmd),
    .period_clk(period_clk), .dead_lh(dead_lh), .dead_hl(dead_hl),
    .min_on(min_on), .max_on(max_on), .min_off(min_off),
    .gh(gh), .gl(gl), .gh_edge(gh_edge), .gh_fine(gh_fine),
    .gl_edge(gl_edge), .gl_fine(gl_fine), .period_start(period_start)
  );

  function automatic int pulse_width(int duty, int p, int a, int b, int mn, int mx, int moff);
    int lo, hi, room, w;
    lo = (mn > 16) ? mn : 16;          // R6
    room = p * 16 - a - b - moff;      // R7
    if (room < 0) room = 0;
    hi = (mx < room) ? mx : room;
    w = duty;
    if (w < lo) w = lo;
    if (w > hi) w = hi;
    return w;
  endfunction

  function automatic logic [12:0] outs();
    return {gh, gl, gh_edge, gh_fine, gl_edge, gl_fine, period_start};
  endfunction

  task automatic check(string tag, logic [12:0] act, logic [12:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: got gh/gl/ghe/ghf/gle/glf/ps=%b expected %b", tag, act, ex);
    end
  endtask

  task automatic step(string tag);
    int a, b, w, k;
    bit hs, ls, he, le;
    int hf, lf;
    if (!chan_en) begin
      m_cnt = 0; m_gh = 0; m_gl = 0;
      expv = '0;
    end else begin
      if (m_cnt == 0) begin
        m_per = (period_clk < 2) ? 2 : int'(period_clk);   // R2
        a = (dead_lh == 0) ? 1 : int'(dead_lh);            // R8
        b = (dead_hl == 0) ? 1 : int'(dead_hl);
        w = pulse_width(int'(duty_cmd), m_per, a, b, int'(min_on), int'(max_on), int'(min_off));
        m_rise = a; m_fall = a + w; m_lson = a + w + b;
      end
      k  = m_cnt;
      hs = (k >= m_rise / 16) && (k < m_fall / 16);        // R5
      ls = (k >= m_lson / 16);
      he = (hs != m_gh);
      le = (ls != m_gl);
      hf = !he ? 0 : (hs ? m_rise % 16 : m_fall % 16);     // R4
      lf = (le && ls) ? m_lson % 16 : 0;
      expv = {hs, ls, he, 4'(hf), le, 4'(lf), (k == 0)};
      m_gh = hs; m_gl = ls;
      m_cnt = (k + 1 == m_per) ? 0 : k + 1;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, outs(), expv);
    checks++;
    if (gh && gl) begin
      errors++;
      $display("FAIL R1: gh=%b gl=%b expected not both high", gh, gl);
    end
  endtask

  task automatic setup(int p, int a, int b, int mn, int mx, int moff, int d);
    period_clk = COARSE_W'(p); dead_lh = TICK_W'(a); dead_hl = TICK_W'(b);
    min_on = TICK_W'(mn); max_on = TICK_W'(mx); min_off = TICK_W'(moff); duty_cmd = TICK_W'(d);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per;
    void'($urandom(32'd20250611));
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset", outs(), 13'b0);
    rst_n = 1'b1;
    setup(20, 24, 20, 40, 200, 32, 100);
    run(3, "R9 disabled");
    // R5 R4: nominal schedule, fine codes off-grid
    chan_en = 1'b1;
    run(60, "R5 R4 nominal");
    // R6: duty below minimum on-time
    duty_cmd = TICK_W'(5);
    run(40, "R6 low clamp");
    min_on = TICK_W'(3);
    run(40, "R6 one-clock floor");
    // R7: maximum on-time and off-time limit
    duty_cmd = TICK_W'(2000);
    run(40, "R7 max_on");
    setup(10, 20, 20, 30, 1000, 40, 900);
    run(30, "R7 room limit");
    setup(4, 30, 30, 40, 1000, 20, 50);
    run(20, "R7 ceiling beats floor");
    // R8: zero dead times
    setup(12, 0, 0, 20, 300, 16, 70);
    run(36, "R8 zero dead");
    // R2: period of 0 and 1, and period change mid period
    setup(1, 5, 5, 16, 100, 0, 16);
    run(10, "R2 short period");
    setup(16, 17, 9, 16, 200, 20, 77);
    run(20, "R2 base");
    period_clk = COARSE_W'(9);
    run(30, "R2 period change");
    // R3: duty change inside a period
    setup(24, 10, 10, 16, 300, 20, 60);
    run(24 + 5, "R3 base");
    duty_cmd = TICK_W'(250);
    run(30, "R3 mid change");
    // R9: disable mid period then re-enable
    run(7, "R9 before");
    chan_en = 1'b0;
    run(4, "R9 off");
    chan_en = 1'b1;
    run(40, "R9 restart");
    // random configurations with mid-period command changes
    for (int t = 0; t < 300; t++) begin
      per = 2 + int'($urandom % 39);
      setup(per, int'($urandom % 41), int'($urandom % 41), int'($urandom % 65),
            int'($urandom % 641), int'($urandom % 65), int'($urandom % 701));
      for (int c = 0; c < 5 + int'($urandom % 80); c++) begin
        if ($urandom % 8 == 0) duty_cmd = TICK_W'($urandom % 701);
        if ($urandom % 97 == 0) chan_en = 1'b0;
        else chan_en = 1'b1;
        step("R3 R4 R5 R6 R7 random");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule